// File: doc/BRIEF.md
# Event-delimited readout data generator

This block holds a queue of 9-bit words loaded by a host and plays them out, one byte at a time, toward a readout system. Bits 7:0 of each word form the byte placed on the output bus. Bit 8 tags the final word of an event, so one store can hold several events of different lengths back to back. Only event boundaries carry a tag. Groups of emulated chips inside an event are not marked.

The readout side supplies a slow external clock and a 2-bit mode. The external clock is synchronised into the system clock domain. While the mode selects readout, every rising and every falling transition of that clock presents the next word. When the tagged word goes out, or a transition finds the store empty, a sticky priority-out token rises and no further words leave. The token drops as soon as the mode leaves readout. The next readout then resumes at the word that follows the tag.

The host loads words through a valid/ready write port. `wr_ready` is low only while the store is full. The host is expected to hold a word until `wr_ready` is high. A word offered while `wr_ready` is low is not held: it is discarded and a sticky overflow flag is set. The output side has no back-pressure. Each emitted byte is marked by a one-cycle `rd_valid` pulse, and `rd_data` holds its value until the next byte. A small control/status register provides store reset and status readback.

Top module: `evgen_top`

## Requirements
- R1: Bytes leave in the order their words were written, and `rd_data` equals bits 7:0 of the word. Bit 8 set marks the last word of an event.
- R2: In mode 2 (readout), each transition of `ext_clk` in either direction emits exactly one word, unless the token is already up. The word is marked by a one-cycle `rd_valid` pulse within 4 `clk` cycles of the transition.
- R3: `prio_out` rises in the same cycle as the `rd_valid` of a word whose bit 8 is set. After that, no word is emitted while the mode stays 2.
- R4: A transition in mode 2 that finds the store empty emits no word and raises `prio_out`.
- R5: `prio_out` is low in the cycle after the mode differs from 2. A later readout continues with the word that follows the tagged word.
- R6: In modes 0 (initialize), 1 (acquire) and 3 (digitize), `ext_clk` transitions emit nothing and leave the stored words intact.
- R7: `ctl_rdata` reports the following status bits: bit 1 overflow, bit 4 full, bit 5 empty and bit 6 the token. Bits 2, 3 and 7 read 0. Writes to the status bits have no effect.
- R8: A register write with bit 0 set empties the store and clears overflow. Bit 0 always reads 0.
- R9: `wr_ready` equals not-full, and writes are accepted in any mode, including during readout. A `wr_valid` while `wr_ready` is low drops the word and sets overflow, which stays set until R8 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host word valid |
| wr_ready | output | 1 | Store can accept a word |
| wr_data | input | 9 | Host word, bit 8 is the event tag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data, bit 0 is store reset |
| ctl_rdata | output | 8 | Control/status readback |
| mode | input | 2 | Latched operating mode, 2 is readout |
| ext_clk | input | 1 | External readout clock, asynchronous |
| rd_data | output | 8 | Emitted byte |
| rd_valid | output | 1 | One-cycle pulse per emitted byte |
| prio_out | output | 1 | Sticky priority-out token |

## Verification
The assertions take `mode` to be synchronous to `clk` and stable for at least a cycle at a time. They also take `ext_clk` transitions to be spaced far enough apart for the synchroniser to resolve each one. The bench changes `mode` and `ext_clk` only on falling `clk` edges and waits six cycles after each transition. The bench issues a store reset only in cycles where no host write is offered. A write offered while `wr_ready` is low is produced only on purpose, to test the overflow path.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MD_INIT    = 2'd0,
    MD_ACQUIRE = 2'd1,
    MD_READOUT = 2'd2,
    MD_DIGIT   = 2'd3
  } mode_e;

  localparam int CB_CLR   = 0;
  localparam int CB_OVF   = 1;
  localparam int CB_FULL  = 4;
  localparam int CB_EMPTY = 5;
  localparam int CB_TOKEN = 6;
endpackage

// File: rtl/evgen_sync.sv
module evgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_stb
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  // either direction of the resolved level counts as one event
  assign edge_stb = sh[STAGES-1] ^ prev;
endmodule

// File: rtl/evgen_fifo.sv
module evgen_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/evgen_ctl.sv
module evgen_ctl
  import evgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       drop,
  input  logic       full,
  input  logic       empty,
  input  logic       token,
  output logic       store_clr,
  output logic [7:0] ctl_rdata
);
  logic ovf;
  logic unused_wbits;

  assign unused_wbits = ^ctl_wdata[7:1];
  assign store_clr    = ctl_wr && ctl_wdata[CB_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (store_clr) ovf <= 1'b0;
    else if (drop)      ovf <= 1'b1;
  end

  always_comb begin
    ctl_rdata           = '0;
    ctl_rdata[CB_OVF]   = ovf;
    ctl_rdata[CB_FULL]  = full;
    ctl_rdata[CB_EMPTY] = empty;
    ctl_rdata[CB_TOKEN] = token;
  end
endmodule

// File: rtl/evgen_rdout.sv
module evgen_rdout
  import evgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              stb,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic              pop,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              halt
);
  logic in_ro;

  assign in_ro = (mode == MD_READOUT);
  assign pop   = in_ro && stb && !halt && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop;
      if (pop) rd_data <= head[BYTE_W-1:0];
      if (!in_ro)
        halt <= 1'b0;
      else if (stb && !halt && (empty || head[WORD_W-1]))
        halt <= 1'b1;
    end
  end
endmodule

// File: rtl/evgen_top.sv
module evgen_top
  import evgen_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic [1:0]        mode,
  input  logic              ext_clk,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              prio_out
);
  logic stb, pop, full, empty, clr, halt;
  logic [WORD_W-1:0] head;

  assign wr_ready = !full;
  assign prio_out = halt;

  evgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .edge_stb(stb)
  );

  evgen_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(wr_valid), .din(wr_data),
    .pop(pop), .head(head), .full(full), .empty(empty)
  );

  evgen_rdout u_rd (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stb(stb), .empty(empty),
    .head(head), .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .halt(halt)
  );

  evgen_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .drop(wr_valid && full), .full(full), .empty(empty), .token(halt),
    .store_clr(clr), .ctl_rdata(ctl_rdata)
  );
endmodule

// File: rtl/evgen_chk.sv
module evgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       rd_valid,
  input logic       prio_out,
  input logic       wr_ready,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata
);
  AST_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |=> !prio_out); // R5
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_out && mode == 2'd2) |=> !rd_valid); // R3
  AST_EMIT_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(mode) == 2'd2)); // R6
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_rdata[4] && ctl_rdata[5])); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[0]) |=> (ctl_rdata[5] && !ctl_rdata[1])); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[1]) && !$past(ctl_wr && ctl_wdata[0])) |-> ctl_rdata[1]); // R9
  AST_READY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == !ctl_rdata[4]); // R9
endmodule

bind evgen_top evgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_valid(rd_valid),
  .prio_out(prio_out), .wr_ready(wr_ready), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
);

// File: tb/evgen_top_tb.sv
module evgen_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_data = '0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [1:0] mode = 2'd1;
  logic       ext_clk = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       prio_out;

  int total = 0;
  int bad = 0;
  int emitted = 0;
  logic [8:0] expq [$];

  always #4 clk = ~clk;

  evgen_top #(.DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mode(mode), .ext_clk(ext_clk),
    .rd_data(rd_data), .rd_valid(rd_valid), .prio_out(prio_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every emitted byte is compared with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      emitted++;
      if (expq.size() == 0) begin
        check("R6 unexpected byte", {24'd0, rd_data}, 32'hdead);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check("R1 byte order", {24'd0, rd_data}, {24'd0, e[7:0]});
        check("R3 token with tag", {31'd0, prio_out}, {31'd0, e[8]});
      end
    end
  end

  task automatic push(input logic [8:0] w, input bit expect_out);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
    if (expect_out) expq.push_back(w);
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic toggle();
    @(negedge clk);
    ext_clk = ~ext_clk;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset status", {24'd0, ctl_rdata}, 32'h20);
    check("R9 ready at reset", {31'd0, wr_ready}, 32'd1);
    check("R3 token low at reset", {31'd0, prio_out}, 32'd0);

    // two events: 3 words and 2 words
    push(9'h011, 1'b1); push(9'h022, 1'b1); push(9'h133, 1'b1);
    push(9'h0A5, 1'b1); push(9'h15A, 1'b1);

    // R6: transitions outside readout do nothing
    toggle(); toggle();
    set_mode(2'd3); toggle();
    check("R6 no emission outside readout", emitted, 32'd0);

    // R2: first event, one byte per transition of either polarity
    set_mode(2'd2);
    toggle();
    check("R2 one byte per edge", emitted, 32'd1);
    toggle(); toggle();
    check("R2 three edges three bytes", emitted, 32'd3);
    check("R3 token after tag", {31'd0, prio_out}, 32'd1);
    check("R7 token bit", {31'd0, ctl_rdata[6]}, 32'd1);
    toggle(); toggle();
    check("R3 silent while token up", emitted, 32'd3);

    // R5: leave readout, token drops, resume with next event
    @(negedge clk); mode = 2'd3;
    @(negedge clk);
    check("R5 token cleared", {31'd0, prio_out}, 32'd0);
    set_mode(2'd2);
    toggle(); toggle();
    check("R5 second event emitted", emitted, 32'd5);
    check("R5 token after second tag", {31'd0, prio_out}, 32'd1);

    // R4: empty store at an edge
    set_mode(2'd1); set_mode(2'd2);
    toggle();
    check("R4 no byte when empty", emitted, 32'd5);
    check("R4 token when empty", {31'd0, prio_out}, 32'd1);

    // R9: write accepted during readout
    set_mode(2'd0); set_mode(2'd2);
    push(9'h1C3, 1'b1);
    toggle();
    check("R9 write in readout emitted", emitted, 32'd6);

    // R9: overflow
    set_mode(2'd1);
    for (int i = 0; i < 8; i++) push(9'(i), 1'b0);
    check("R9 ready low when full", {31'd0, wr_ready}, 32'd0);
    check("R7 full status", {24'd0, ctl_rdata}, 32'h10);
    push(9'h0FF, 1'b0);
    check("R9 overflow sticky", {24'd0, ctl_rdata}, 32'h12);

    // R7: writes to status bits ignored
    ctl(8'hFE);
    check("R7 status write ignored", {24'd0, ctl_rdata}, 32'h12);

    // R8: store reset
    ctl(8'h01);
    check("R8 cleared and bit0 reads 0", {24'd0, ctl_rdata}, 32'h20);
    base = emitted;
    set_mode(2'd2);
    toggle();
    check("R8 nothing left to emit", emitted, base);
    check("R1 scoreboard drained", expq.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule